// File: doc/BRIEF.md
# LCD Sync and Pixel Timing Generator

This block produces the raster timing for a 320x240 TFT panel that is fed over a parallel port. Every count is kept in port clocks. Depending on the pixel transport mode, one pixel takes one, two or three port clocks. The block drives active-low horizontal and vertical sync and a data-valid strobe. It also exposes the frame line number, the port-clock position within the line and the active pixel index. An upstream fetch engine uses these counters to address the pixel it must present while data-valid is high.

There is no data path through the block. The outputs follow a fixed schedule and do not wait on a consumer, so the interface has no ready and no back-pressure. A consumer that cannot keep pace must buffer on its own side. Software picks a transport mode with enable low and then raises enable. Counting starts from line 0, clock 0 at that point. The mode cannot be changed until enable drops again.

Top module: `lcd_sync_gen`

## Requirements
- R1: `mode_sel` encodings: 0 = 16-bit 565 transport (1 clock per pixel, start correction 0), 1 = 8-bit 565 transport (2 clocks per pixel, correction 3), 2 = 8-bit 888 transport (3 clocks per pixel, correction 5), 3 = illegal.
- R2: A line lasts 336 x cpp port clocks. `pos_cnt` counts 0 up to 336 x cpp - 1, then returns to 0 and `line_cnt` advances.
- R3: `hsync_n` is low exactly while `pos_cnt` < 2 x cpp, on every line.
- R4: `data_valid` is high exactly on lines 2 to 241 while `pos_cnt` is in [7 x cpp + correction, 7 x cpp + correction + 320 x cpp).
- R5: A frame has 244 lines. `line_cnt` wraps from 243 to 0, so the vertical period is 244 line periods.
- R6: `vsync_n` is low exactly on line 0 while `pos_cnt` < 2 x cpp.
- R7: While `data_valid` is high, `pix_idx` = (`pos_cnt` - start) / cpp, where start is 7 x cpp + correction. Otherwise `pix_idx` is 0.
- R8: While `enable` is low, the syncs are high, `data_valid` is low and all counters are 0, from the next clock edge onward. `mode_sel` is captured only while `enable` is low, and changes while enabled have no effect. After the first edge that samples `enable` high, the outputs show line 0, clock 0.
- R9: With the illegal mode captured, enabling leaves the syncs high, `data_valid` low and the counters at 0.
- R10: Asynchronous active-low `rst_n` puts the block in the idle state with mode 0 captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Run timing when high; idle and capture mode when low |
| mode_sel | input | 2 | Pixel transport mode select |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| data_valid | output | 1 | High while an active pixel is on the port |
| line_cnt | output | 8 | Frame line number, 0..243 |
| pos_cnt | output | 10 | Port-clock position within the line |
| pix_idx | output | 9 | Active pixel index within the line |

## Verification
The 16-bit mode is run for a full frame plus a margin. This exercises the line 0 vertical pulse, the first and last active lines (2 and 241), the blank lines around them and the 243-to-0 wrap. Each 8-bit mode is run for several lines. These runs separate the per-mode clocks-per-pixel scaling from the start correction: a fault in either one moves the first data-valid clock or the pixel-index steps by a different amount. Random segments mix the legal and illegal modes with random lengths, so enable often drops mid-line. During each run, `mode_sel` is toggled at random so that capturing it outside idle would be detected.

// File: rtl/lcd_sync_pkg.sv
package lcd_sync_pkg;

  typedef enum logic [1:0] {
    XFER_W16_565 = 2'd0,
    XFER_W8_565  = 2'd1,
    XFER_W8_888  = 2'd2,
    XFER_BAD     = 2'd3
  } xfer_mode_e;

  localparam int unsigned MAX_CPP = 3;

  function automatic int unsigned clocks_per_pix(input xfer_mode_e m);
    case (m)
      XFER_W16_565: return 1;
      XFER_W8_565:  return 2;
      XFER_W8_888:  return 3;
      default:      return 0;
    endcase
  endfunction

  function automatic logic mode_ok(input xfer_mode_e m);
    return m != XFER_BAD;
  endfunction

endpackage

// File: rtl/lcd_mode_table.sv
module lcd_mode_table
  import lcd_sync_pkg::*;
#(
  parameter int unsigned H_TOT        = 336,
  parameter int unsigned H_ACT        = 320,
  parameter int unsigned H_PULSE      = 2,
  parameter int unsigned H_LEAD       = 7,
  parameter int unsigned V_PULSE      = 2,
  parameter int unsigned CORR_W8_565  = 3,
  parameter int unsigned CORR_W8_888  = 5,
  parameter int unsigned POS_W        = 10
) (
  input  xfer_mode_e       mode,
  output logic             legal,
  output logic [1:0]       cpp_m1,
  output logic [POS_W-1:0] period_m1,
  output logic [POS_W-1:0] hs_width,
  output logic [POS_W-1:0] vs_width,
  output logic [POS_W-1:0] act_start,
  output logic [POS_W-1:0] act_end
);

  int unsigned cpp_i;
  int unsigned corr_i;

  always_comb begin
    cpp_i  = clocks_per_pix(mode);
    legal  = mode_ok(mode);
    case (mode)
      XFER_W8_565: corr_i = CORR_W8_565;
      XFER_W8_888: corr_i = CORR_W8_888;
      default:     corr_i = 0;
    endcase
    if (legal) begin
      cpp_m1    = 2'(cpp_i - 1);
      period_m1 = POS_W'(H_TOT * cpp_i - 1);
      hs_width  = POS_W'(H_PULSE * cpp_i);
      vs_width  = POS_W'(V_PULSE * cpp_i);
      act_start = POS_W'(H_LEAD * cpp_i + corr_i);
      act_end   = POS_W'(H_LEAD * cpp_i + corr_i + H_ACT * cpp_i);
    end else begin
      cpp_m1    = '0;
      period_m1 = '0;
      hs_width  = '0;
      vs_width  = '0;
      act_start = '0;
      act_end   = '0;
    end
  end

endmodule

// File: rtl/lcd_raster_cnt.sv
module lcd_raster_cnt #(
  parameter int unsigned POS_W  = 10,
  parameter int unsigned LINE_W = 8,
  parameter int unsigned V_TOT  = 244
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              legal,
  input  logic [POS_W-1:0]  period_m1,
  output logic              run,
  output logic [POS_W-1:0]  pos,
  output logic [LINE_W-1:0] line
);

  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(V_TOT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run  <= 1'b0;
      pos  <= '0;
      line <= '0;
    end else if (!enable) begin
      run  <= 1'b0;
      pos  <= '0;
      line <= '0;
    end else if (!run) begin
      run <= legal;
    end else if (pos == period_m1) begin
      pos  <= '0;
      line <= (line == LAST_LINE) ? '0 : line + 1'b1;
    end else begin
      pos <= pos + 1'b1;
    end
  end

  a_r2_pos_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> pos <= period_m1);

  a_r5_line_bound: assert property (@(posedge clk) disable iff (!rst_n)
    line <= LAST_LINE);

  a_r5_line_moves_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && line != $past(line)) |-> ($past(pos) == period_m1 && pos == '0));

endmodule

// File: rtl/lcd_pixel_index.sv
module lcd_pixel_index #(
  parameter int unsigned POS_W = 10,
  parameter int unsigned PIX_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [POS_W-1:0] pos,
  input  logic [POS_W-1:0] act_start,
  input  logic [1:0]       cpp_m1,
  output logic [PIX_W-1:0] pidx
);

  logic [1:0] phase;
  logic       at_pre_start;

  assign at_pre_start = (pos == act_start - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
      pidx  <= '0;
    end else if (!advance) begin
      phase <= '0;
      pidx  <= '0;
    end else if (at_pre_start) begin
      phase <= '0;
      pidx  <= '0;
    end else if (phase == cpp_m1) begin
      phase <= '0;
      pidx  <= pidx + 1'b1;
    end else begin
      phase <= phase + 1'b1;
    end
  end

  a_r7_phase_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phase <= cpp_m1 || phase == '0);

endmodule

// File: rtl/lcd_sync_decode.sv
module lcd_sync_decode #(
  parameter int unsigned POS_W   = 10,
  parameter int unsigned LINE_W  = 8,
  parameter int unsigned PIX_W   = 9,
  parameter int unsigned V_FIRST = 2,
  parameter int unsigned V_LAST  = 241
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [POS_W-1:0]  pos,
  input  logic [LINE_W-1:0] line,
  input  logic [POS_W-1:0]  hs_width,
  input  logic [POS_W-1:0]  vs_width,
  input  logic [POS_W-1:0]  act_start,
  input  logic [POS_W-1:0]  act_end,
  input  logic [PIX_W-1:0]  pidx,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              data_valid,
  output logic [PIX_W-1:0]  pix_idx
);

  logic line_active;
  logic span_active;

  always_comb begin
    line_active = (line >= LINE_W'(V_FIRST)) && (line <= LINE_W'(V_LAST));
    span_active = (pos >= act_start) && (pos < act_end);
    hsync_n     = !(run && pos < hs_width);
    vsync_n     = !(run && line == '0 && pos < vs_width);
    data_valid  = run && line_active && span_active;
    pix_idx     = data_valid ? pidx : '0;
  end

  a_r4_valid_clear_of_syncs: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (hsync_n && vsync_n));

  a_r6_vsync_on_line0: assert property (@(posedge clk) disable iff (!rst_n)
    !vsync_n |-> line == '0);

  a_r7_pix_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (data_valid && $past(data_valid)) |->
      (pix_idx == $past(pix_idx) || pix_idx == $past(pix_idx) + 1'b1));

endmodule

// File: rtl/lcd_sync_gen.sv
module lcd_sync_gen
  import lcd_sync_pkg::*;
#(
  parameter int unsigned H_TOT       = 336,
  parameter int unsigned H_ACT       = 320,
  parameter int unsigned H_PULSE     = 2,
  parameter int unsigned H_LEAD      = 7,
  parameter int unsigned V_ACT       = 240,
  parameter int unsigned V_TOP       = 2,
  parameter int unsigned V_BOT       = 2,
  parameter int unsigned V_PULSE     = 2,
  parameter int unsigned CORR_W8_565 = 3,
  parameter int unsigned CORR_W8_888 = 5,
  localparam int unsigned V_TOT      = V_TOP + V_ACT + V_BOT,
  localparam int unsigned POS_W      = $clog2(H_TOT * MAX_CPP),
  localparam int unsigned LINE_W     = $clog2(V_TOT),
  localparam int unsigned PIX_W      = $clog2(H_ACT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode_sel,
  output logic              hsync_n,
  output logic              vsync_n,
  output logic              data_valid,
  output logic [LINE_W-1:0] line_cnt,
  output logic [POS_W-1:0]  pos_cnt,
  output logic [PIX_W-1:0]  pix_idx
);

  xfer_mode_e       mode_q;
  logic             legal;
  logic [1:0]       cpp_m1;
  logic [POS_W-1:0] period_m1, hs_width, vs_width, act_start, act_end;
  logic             run;
  logic [PIX_W-1:0] pidx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= XFER_W16_565;
    else if (!enable) mode_q <= xfer_mode_e'(mode_sel);
  end

  lcd_mode_table #(
    .H_TOT(H_TOT), .H_ACT(H_ACT), .H_PULSE(H_PULSE), .H_LEAD(H_LEAD),
    .V_PULSE(V_PULSE), .CORR_W8_565(CORR_W8_565), .CORR_W8_888(CORR_W8_888),
    .POS_W(POS_W)
  ) u_table (
    .mode(mode_q), .legal(legal), .cpp_m1(cpp_m1), .period_m1(period_m1),
    .hs_width(hs_width), .vs_width(vs_width), .act_start(act_start),
    .act_end(act_end)
  );

  lcd_raster_cnt #(.POS_W(POS_W), .LINE_W(LINE_W), .V_TOT(V_TOT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .enable(enable), .legal(legal),
    .period_m1(period_m1), .run(run), .pos(pos_cnt), .line(line_cnt)
  );

  lcd_pixel_index #(.POS_W(POS_W), .PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .advance(run && enable), .pos(pos_cnt),
    .act_start(act_start), .cpp_m1(cpp_m1), .pidx(pidx)
  );

  lcd_sync_decode #(
    .POS_W(POS_W), .LINE_W(LINE_W), .PIX_W(PIX_W),
    .V_FIRST(V_TOP), .V_LAST(V_TOP + V_ACT - 1)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .run(run), .pos(pos_cnt), .line(line_cnt),
    .hs_width(hs_width), .vs_width(vs_width), .act_start(act_start),
    .act_end(act_end), .pidx(pidx), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .data_valid(data_valid), .pix_idx(pix_idx)
  );

  a_r8_idle_after_disable: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (hsync_n && vsync_n && !data_valid && pos_cnt == '0 && line_cnt == '0));

  a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable)) |-> $stable(mode_q));

  a_r9_bad_mode_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XFER_BAD) |-> (hsync_n && vsync_n && !data_valid && pos_cnt == '0));

endmodule

// File: tb/lcd_sync_gen_tb_top.sv
module lcd_sync_gen_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic       hsync_n, vsync_n, data_valid;
  logic [7:0] line_cnt;
  logic [9:0] pos_cnt;
  logic [8:0] pix_idx;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lcd_sync_gen dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_sel(mode_sel),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .data_valid(data_valid),
    .line_cnt(line_cnt), .pos_cnt(pos_cnt), .pix_idx(pix_idx)
  );

  // R1: mode to clocks per pixel and start correction
  function automatic int cpp_f(input int m);
    return (m == 0) ? 1 : (m == 1) ? 2 : (m == 2) ? 3 : 0;
  endfunction
  function automatic int corr_f(input int m);
    return (m == 1) ? 3 : (m == 2) ? 5 : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " hsync_n"}, hsync_n, 1);
    chk({tag, " vsync_n"}, vsync_n, 1);
    chk({tag, " data_valid"}, data_valid, 0);
    chk({tag, " line_cnt"}, line_cnt, 0);
    chk({tag, " pos_cnt"}, pos_cnt, 0);
    chk({tag, " pix_idx"}, pix_idx, 0);
  endtask

  // compare all outputs with the expected values for enabled cycle k
  task automatic chk_cycle(input int m, input int k);
    int cpp, per, pos, line, hst, dv, pix;
    cpp = cpp_f(m);
    if (cpp == 0) begin
      chk_idle("R9 illegal mode");
      return;
    end
    per  = 336 * cpp;
    pos  = k % per;
    line = (k / per) % 244;
    hst  = 7 * cpp + corr_f(m);
    dv   = (line >= 2 && line <= 241 && pos >= hst && pos < hst + 320 * cpp) ? 1 : 0;
    pix  = dv ? (pos - hst) / cpp : 0;
    chk("R2 pos_cnt", pos_cnt, pos);
    chk("R5 line_cnt", line_cnt, line);
    chk("R3 hsync_n", hsync_n, (pos < 2 * cpp) ? 0 : 1);
    chk("R6 vsync_n", vsync_n, (line == 0 && pos < 2 * cpp) ? 0 : 1);
    chk("R4 data_valid", data_valid, dv);
    chk("R7 pix_idx", pix_idx, pix);
  endtask

  // R8: capture mode while idle, enable, run n cycles, then disable
  task automatic run_seg(input int m, input int n);
    @(negedge clk);
    enable   = 1'b0;
    mode_sel = 2'(m);
    @(negedge clk);
    enable = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk_cycle(m, k);
      if (($urandom % 64) == 0) mode_sel = 2'($urandom % 4); // R8: ignored
    end
    enable = 1'b0;
    @(negedge clk);
    chk_idle("R8 after disable");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk_idle("R10 in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_idle("R8 idle enable low");
    // full frame in 16-bit mode: line 0 pulse, lines 2/241 edges, wrap (R5)
    run_seg(0, 336 * 244 + 700);
    run_seg(1, 672 * 4 + 40);
    run_seg(2, 1008 * 4 + 40);
    run_seg(3, 60);       // R9
    for (int i = 0; i < 8; i++) begin
      run_seg(int'($urandom % 4), 100 + int'($urandom % 2500));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < 195000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule